// File: doc/BRIEF.md
# Dual-Password Secret Register

This peripheral sits on a processor's control/status register bus and releases one built-in 32-bit secret word only after software has presented two correct 32-bit passwords. Software writes one password candidate to each of two register offsets. The block holds each candidate in its own register and compares it with its own fixed 32-bit key. When software reads the secret offset, the returned word is the secret ANDed bit by bit with the AND of both match results. Every bit of the secret is therefore visible only while both candidates are correct, and the read returns all zeros otherwise.

The upper address bits select the block against a base parameter. Inside the block, the low address bits form the register offset. Read data is registered, and it reads as zero for any address that does not hit the secret offset. The block can therefore share an OR-combined read-data bus with other peripherals.

Top module: `csr_secret_gate`

## Requirements
- R1: After reset both candidate registers hold zero and `csr_do` is zero, so a read of the secret offset (offset 2) returns zero until both passwords are written.
- R2: The block is selected when `csr_a[ADDR_W-1:SEL_LSB]` equals `BASE`. The offset is `csr_a[SEL_LSB-1:0]`.
- R3: A write (`csr_we`=1) to offset 0 of the selected block loads `csr_di` into the first candidate register.
- R4: A write to offset 1 of the selected block loads `csr_di` into the second candidate register.
- R5: A read of offset 2 returns `SECRET` when the first candidate equals `KEY_A` and the second equals `KEY_B`. The data appears on `csr_do` one clock after the address is presented.
- R6: A read of offset 2 returns zero when either candidate differs from its key in any bit.
- R7: Reads of offsets 0, 1 and of every offset other than 2 return zero.
- R8: Reads of addresses outside the block return zero. Writes outside the block leave both candidates unchanged.
- R9: A password write changes the read result for a read of offset 2 presented on the very next cycle.
- R10: Writes to offset 2, or to any offset above 2, change neither candidate. A read is performed on every cycle whether or not `csr_we` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csr_a | input | ADDR_W | Word address: block select in the upper bits, offset in the lower bits |
| csr_we | input | 1 | Write strobe for the address on `csr_a` |
| csr_di | input | 32 | Write data |
| csr_do | output | 32 | Registered read data, zero when not addressing the secret |

## Verification
A candidate register that is stored wrongly or left stale shows up at the ports only through the secret read. A wrong match result gives either zero where the secret is expected or the secret where zero is expected, on the cycle after the secret address is presented. The bench flips each key bit in turn, one at a time, and reads right after every write, so a fault in one comparator bit or a one-cycle slip in write timing is exposed within two cycles. Sweeping every block-select value and every offset exposes a decode fault the first time the wrong address leaks the secret or suppresses it.

// File: rtl/csr_secret_gate.sv
module csr_secret_gate #(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned SEL_LSB = 10,
  parameter int unsigned BASE    = 5,
  parameter logic [31:0] KEY_A   = 32'h6D3A_91C4,
  parameter logic [31:0] KEY_B   = 32'hB20F_5E87,
  parameter logic [31:0] SECRET  = 32'hC0DE_F00D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_a,
  input  logic              csr_we,
  input  logic [31:0]       csr_di,
  output logic [31:0]       csr_do
);
  localparam int unsigned BLK_W = ADDR_W - SEL_LSB;
  localparam int unsigned OFF_W = SEL_LSB;
  localparam logic [BLK_W-1:0] BASE_V   = BLK_W'(BASE);
  localparam logic [OFF_W-1:0] OFF_PW_A = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_PW_B = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_SEC  = OFF_W'(2);

  logic [31:0] cand_a, cand_b;
  logic        sel, hit_a, hit_b, hit_sec;
  logic        match_a, match_b, open;

  assign sel     = (csr_a[ADDR_W-1:SEL_LSB] == BASE_V);
  assign hit_a   = sel && (csr_a[OFF_W-1:0] == OFF_PW_A);
  assign hit_b   = sel && (csr_a[OFF_W-1:0] == OFF_PW_B);
  assign hit_sec = sel && (csr_a[OFF_W-1:0] == OFF_SEC);

  assign match_a = (cand_a == KEY_A);
  assign match_b = (cand_b == KEY_B);
  assign open    = match_a & match_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_a <= '0;
      cand_b <= '0;
    end else if (csr_we) begin
      if (hit_a) cand_a <= csr_di;
      if (hit_b) cand_b <= csr_di;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) csr_do <= '0;
    else     csr_do <= hit_sec ? (SECRET & {32{open}}) : 32'd0;
  end

  assert_load_a_R3: assert property (@(posedge clk) disable iff (rst)
    (csr_we && hit_a) |=> (cand_a == $past(csr_di)));
  assert_load_b_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_we && hit_b) |=> (cand_b == $past(csr_di)));
  assert_hold_a_R10: assert property (@(posedge clk) disable iff (rst)
    !(csr_we && hit_a) |=> $stable(cand_a));
  assert_hold_b_R8: assert property (@(posedge clk) disable iff (rst)
    !(csr_we && hit_b) |=> $stable(cand_b));
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (hit_sec && match_a && match_b) |=> (csr_do == SECRET));
  assert_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_sec && !(match_a && match_b)) |=> (csr_do == 32'd0));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !hit_sec |=> (csr_do == 32'd0));
endmodule

// File: tb/csr_secret_gate_tb.sv
module csr_secret_gate_tb;
  localparam int unsigned ADDR_W  = 14;
  localparam int unsigned SEL_LSB = 10;
  localparam int unsigned BASE    = 5;
  localparam logic [31:0] KA = 32'h6D3A_91C4;
  localparam logic [31:0] KB = 32'hB20F_5E87;
  localparam logic [31:0] SC = 32'hC0DE_F00D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] csr_a = '0;
  logic csr_we = 1'b0;
  logic [31:0] csr_di = '0;
  logic [31:0] csr_do;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] ma = '0, mb = '0;

  always #5 clk = ~clk;

  csr_secret_gate #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .BASE(BASE),
    .KEY_A(KA), .KEY_B(KB), .SECRET(SC)) u_dut (
    .clk(clk), .rst(rst), .csr_a(csr_a), .csr_we(csr_we),
    .csr_di(csr_di), .csr_do(csr_do));

  function automatic logic [ADDR_W-1:0] adr(input int blk, input int off);
    return ADDR_W'((blk << SEL_LSB) | off);
  endfunction

  function automatic logic [31:0] expect_rd(input int blk, input int off);
    return (blk == BASE && off == 2 && ma == KA && mb == KB) ? SC : 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input int blk, input int off, input logic we, input logic [31:0] d,
                        input string tag);
    logic [31:0] e;
    @(negedge clk);
    csr_a = adr(blk, off); csr_we = we; csr_di = d;
    e = expect_rd(blk, off);
    if (we && blk == BASE && off == 0) ma = d;
    if (we && blk == BASE && off == 1) mb = d;
    @(negedge clk);
    csr_we = 1'b0;
    check(tag, csr_do, e);
  endtask

  task automatic rd(input int blk, input int off, input string tag);
    access(blk, off, 1'b0, 32'd0, tag);
  endtask

  task automatic wr(input int blk, input int off, input logic [31:0] d, input string tag);
    access(blk, off, 1'b1, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 csr_do after reset", csr_do, 32'd0);
    rst = 1'b0;
    rd(BASE, 2, "R1 secret locked after reset");

    wr(BASE, 0, KA, "R3 write first password");
    rd(BASE, 2, "R6 only first password correct");
    wr(BASE, 1, KB, "R4 write second password");
    rd(BASE, 2, "R5 both passwords correct");

    for (int off = 0; off < 8; off++)
      rd(BASE, off, (off == 2) ? "R5 offset sweep secret" : "R7 offset sweep zero");
    for (int blk = 0; blk < 16; blk++)
      rd(blk, 2, (blk == BASE) ? "R2 block sweep selected" : "R8 block sweep outside");

    for (int off = 2; off < 8; off++) begin
      wr(BASE, off, 32'h0, "R10 write to non-password offset");
      rd(BASE, 2, "R10 still unlocked");
    end

    for (int blk = 0; blk < 16; blk++) begin
      if (blk == BASE) continue;
      wr(blk, 0, 32'h0, "R8 outside write offset 0");
      wr(blk, 1, 32'h0, "R8 outside write offset 1");
      rd(BASE, 2, "R8 still unlocked after outside writes");
    end

    for (int i = 0; i < 32; i++) begin
      wr(BASE, 0, KA ^ (32'd1 << i), "R9 bit flip first password");
      rd(BASE, 2, "R6 first password one bit off");
      wr(BASE, 0, KA, "R9 restore first password");
      rd(BASE, 2, "R9 unlocked next cycle");
    end
    for (int i = 0; i < 32; i++) begin
      wr(BASE, 1, KB ^ (32'd1 << i), "R9 bit flip second password");
      rd(BASE, 2, "R6 second password one bit off");
      wr(BASE, 1, KB, "R9 restore second password");
      rd(BASE, 2, "R9 unlocked next cycle");
    end

    wr(BASE, 0, KB, "R3 swapped keys");
    wr(BASE, 1, KA, "R4 swapped keys");
    rd(BASE, 2, "R6 swapped keys locked");
    wr(BASE, 0, KA, "R3 rewrite");
    wr(BASE, 1, KB, "R4 rewrite");
    wr(BASE, 2, 32'hFFFF_FFFF, "R10 read happens during write cycle");

    @(negedge clk); rst = 1'b1; ma = '0; mb = '0;
    @(negedge clk); rst = 1'b0;
    check("R1 csr_do after second reset", csr_do, 32'd0);
    rd(BASE, 2, "R1 locked after second reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule